// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Stuck-Bus Timeout

This block is the serial front end of a port-expander style device. It watches the two wires of an I2C bus (clock and data) with a fast system clock and answers one device address. The upper five address bits are fixed and the lowest two come from strap pins. Behind it sits a 64-entry byte-wide register file. A write transfer carries a command byte first, which becomes the register pointer. The bytes after it are stored at the pointer, and the pointer steps by one after each byte. A read transfer streams bytes out from the stored pointer, which also steps after each byte. The pointer is kept between transfers, so a master may set it with a short write and then read, with or without a repeated START in between.

An optional watchdog returns the serial state machine to idle when a wire is held low during a transfer for longer than a parameterised number of system clocks. It is switched off by bit 7 of register 0x27. The watchdog never alters the register contents.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The device address is the 7-bit value 1,0,0,1,1,A1,A0 sent MSB first, where A1/A0 are `addr_pins[1]`/`addr_pins[0]`, followed by the direction bit (1 = read). On a match the slave pulls SDA low during the 9th clock. On any other address it leaves SDA released and ignores the bus until the next START.
- R2: In a write transfer, the first byte after the address acknowledge is acknowledged and loads the register pointer from its low 6 bits. No register is changed by it.
- R3: Each further byte of a write transfer is acknowledged and stored in the register the pointer selects, after which the pointer increases by one.
- R4: A read transfer shifts out the byte at the pointer, MSB first, one bit per SCL low phase, then increases the pointer. It sends the next byte while the master acknowledges (SDA low in the 9th clock).
- R5: A not-acknowledge from the master ends the read. SDA is released from the 9th clock onward and no more bytes are driven.
- R6: A repeated START keeps the pointer and takes the new direction from the new address byte.
- R7: The pointer is kept across STOP and used by the next transfer.
- R8: The pointer is 6 bits wide and wraps from 0x3F to 0x00.
- R9: A START or STOP in the middle of a byte abandons that byte, and no register is written from it.
- R10: When bit 7 of register 0x27 is 0, SCL or SDA held low for TIMEOUT_CYCLES system clocks with no SCL edge during a transfer returns the slave to idle with SDA released. Register contents are kept.
- R11: When bit 7 of register 0x27 is 1, the timeout never acts.
- R12: After reset every register is 0x00, the pointer is 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| addr_pins | input | 2 | Strap pins for the two low address bits |
| sda_oe | output | 1 | 1 pulls the data wire low (open-drain enable) |

## Verification
The assertions assume that SCL and SDA are clean, already debounced levels. They assume that SDA only changes while SCL is low, except for START and STOP, and that each SCL phase lasts well beyond the synchroniser delay of about four system clocks. The bench's master model keeps every SCL half period at 12 clocks and moves SDA only in the middle of the low phase, so every START and STOP it makes is deliberate. The watchdog limit is shortened to 400 clocks so that stuck-wire cases are reached. In normal transfers the longest quiet stretch is far below that limit.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    // Fixed upper part of the device address
    localparam logic [4:0] DEV_ID_HI = 5'b10011;

    // Register holding the timeout disable flag
    localparam int CFG_REG_INDEX  = 'h27;
    localparam int CFG_TMO_DIS_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } ser_state_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_CMD,
        RX_DATA
    } rx_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [7:0] rx, input logic [1:0] pins);
        return rx[7:1] == {DEV_ID_HI, pins};
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_p, sda_p;
    logic scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2cs_watchdog.sv
module i2cs_watchdog #(
    parameter int LIMIT = 6000000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic busy,
    input  logic scl,
    input  logic sda,
    input  logic scl_edge,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable || !busy || scl_edge || (scl && sda)) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (cnt == CW'(LIMIT - 1)) begin
            cnt     <= '0;
            expired <= 1'b1;
        end else begin
            cnt     <= cnt + 1'b1;
            expired <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    output logic          tmo_dis
);

    logic [7:0] rd_vec [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 8'h00;
            else if (we && waddr == AW'(g))
                q <= wdata;
        end
        assign rd_vec[g] = q;
    end

    assign rdata   = rd_vec[raddr];
    assign tmo_dis = rd_vec[CFG_REG_INDEX][CFG_TMO_DIS_BIT];

endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
    import i2cs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [1:0]    addr_pins,
    input  logic          tmo_hit,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] ptr,
    output ser_state_e    state,
    output logic          busy
);

    rx_kind_e   kind;
    logic       rw;
    logic       mack_ok;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       byte_done;
    logic       abort;

    assign byte_done = (state == ST_RX) && ev.scl_fall && (bitcnt == 4'd8);
    assign abort     = tmo_hit | ev.start | ev.stop;
    assign wr_en     = byte_done && (kind == RX_DATA) && !abort;
    assign wr_data   = shreg;
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind    <= RX_ADDR;
            rw      <= 1'b0;
            mack_ok <= 1'b0;
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
        end else if (tmo_hit) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_RX;
            kind   <= RX_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_RX: begin
                    if (ev.scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        unique case (kind)
                            RX_ADDR: begin
                                if (addr_hit(shreg, addr_pins)) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            RX_CMD: begin
                                ptr    <= shreg[AW-1:0];
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                            end
                            default: begin
                                ptr    <= ptr + 1'b1;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (kind == RX_ADDR && rw) begin
                            state  <= ST_TX;
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            state  <= ST_RX;
                            kind   <= (kind == RX_ADDR) ? RX_CMD : RX_DATA;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            state  <= ST_MACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        mack_ok <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack_ok) begin
                            state  <= ST_TX;
                            bitcnt <= '0;
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2cs_pkg::*;
#(
    parameter int REG_COUNT      = 64,
    parameter int TIMEOUT_CYCLES = 6000000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] addr_pins,
    output logic       sda_oe
);

    localparam int AW = $clog2(REG_COUNT);

    bus_ev_t    ev;
    ser_state_e fsm_state;
    logic [AW-1:0] ptr;
    logic [7:0] rd_data, wr_data;
    logic wr_en, busy, tmo_hit, tmo_dis;
    logic start_det, stop_det;

    assign start_det = ev.start;
    assign stop_det  = ev.stop;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i), .ev(ev)
    );

    i2cs_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wdog (
        .clk(clk), .rst(rst), .enable(!tmo_dis), .busy(busy),
        .scl(ev.scl), .sda(ev.sda), .scl_edge(ev.scl_rise | ev.scl_fall),
        .expired(tmo_hit)
    );

    i2cs_proto #(.AW(AW)) u_proto (
        .clk(clk), .rst(rst), .ev(ev), .addr_pins(addr_pins),
        .tmo_hit(tmo_hit), .rd_data(rd_data), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr),
        .state(fsm_state), .busy(busy)
    );

    i2cs_regs #(.DEPTH(REG_COUNT), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .we(wr_en), .waddr(ptr), .wdata(wr_data),
        .raddr(ptr), .rdata(rd_data), .tmo_dis(tmo_dis)
    );

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          sda_oe,
    input ser_state_e    state,
    input logic [AW-1:0] ptr,
    input logic          we,
    input logic          start_det,
    input logic          stop_det,
    input logic          tmo_hit,
    input logic          tmo_dis
);

    assert_reset_clean_R12: assert property (@(posedge clk)
        rst |=> (!sda_oe && ptr == '0 && state == ST_IDLE));

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    assert_restart_keeps_ptr_R6: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (ptr == $past(ptr) && state == ST_RX));

    assert_write_steps_ptr_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> (ptr == AW'($past(ptr) + 1'b1)));

    assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (we && ptr == '1) |=> (ptr == '0));

    assert_timeout_idle_R10: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> (state == ST_IDLE && !sda_oe));

    assert_timeout_off_R11: assert property (@(posedge clk) disable iff (rst)
        tmo_dis |=> !tmo_hit);

endmodule

bind i2c_regfile_slave i2cs_checker #(.AW(AW)) u_checker (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .state(fsm_state), .ptr(ptr),
    .we(wr_en), .start_det(start_det), .stop_det(stop_det),
    .tmo_hit(tmo_hit), .tmo_dis(tmo_dis)
);

// File: tb/i2c_regfile_slave_test.sv
`timescale 1ns/1ps
module i2c_regfile_slave_test;

    localparam int TMO = 400;
    localparam int Q   = 6;
    localparam logic [1:0] PINS = 2'b10;
    localparam logic [6:0] DEV  = {5'b10011, PINS};

    // {pointer, data} written then read back
    localparam logic [13:0] VEC [8] = '{
        {6'h01, 8'h5A}, {6'h02, 8'hA5}, {6'h10, 8'h3C}, {6'h20, 8'hFF},
        {6'h2A, 8'h81}, {6'h30, 8'h7E}, {6'h05, 8'h01}, {6'h3E, 8'hC0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #2.5 clk = ~clk;

    i2c_regfile_slave #(.TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .addr_pins(PINS), .sda_oe(sda_oe)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
        s = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic give_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(~give_ack, s);
    endtask

    // write: pointer byte then n data bytes from wbuf
    task automatic wr_seq(input logic [7:0] p, input int n);
        logic ack;
        bus_start();
        write_byte({DEV, 1'b0}, ack); check("R1 addr ack", ack, 1);
        write_byte(p, ack);           check("R2 cmd ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            write_byte(wbuf[i], ack); check("R3 data ack", ack, 1);
        end
        bus_stop();
    endtask

    // set pointer, repeated start, read n bytes into rbuf
    task automatic rd_seq(input logic [7:0] p, input int n);
        logic ack;
        bus_start();
        write_byte({DEV, 1'b0}, ack); check("R1 addr ack", ack, 1);
        write_byte(p, ack);           check("R2 cmd ack", ack, 1);
        bus_rstart();
        write_byte({DEV, 1'b1}, ack); check("R6 read addr ack", ack, 1);
        for (int i = 0; i < n; i++) read_byte(rbuf[i], i < n - 1);
        check("R5 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic rd_cur(input int n);
        logic ack;
        bus_start();
        write_byte({DEV, 1'b1}, ack); check("R1 addr ack", ack, 1);
        for (int i = 0; i < n; i++) read_byte(rbuf[i], i < n - 1);
        bus_stop();
    endtask

    initial begin
        logic ack, s;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R12: reset state
        check("R12 sda released", sda_oe, 0);
        rd_cur(1);
        check("R12 reg 0x00 after reset", rbuf[0], 8'h00);

        // Vector table: write then read back each entry (R2, R3, R4, R6)
        foreach (VEC[k]) begin
            wbuf[0] = VEC[k][7:0];
            wr_seq({2'b00, VEC[k][13:8]}, 1);
            rd_seq({2'b00, VEC[k][13:8]}, 1);
            check("R4 R6 table readback", rbuf[0], VEC[k][7:0]);
        end

        // R1: foreign address gets no ack and its bytes change nothing
        bus_start();
        write_byte({5'b10011, 2'b01, 1'b0}, ack);
        check("R1 foreign addr nack", ack, 0);
        write_byte(8'h01, ack);
        check("R1 ignored byte nack", ack, 0);
        write_byte(8'hEE, ack);
        check("R1 sda released", sda_oe, 0);
        bus_stop();
        rd_seq(8'h01, 1);
        check("R1 reg 0x01 unchanged", rbuf[0], 8'h5A);

        // R3/R4: burst write and burst read, R7 pointer persistence
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44; wbuf[4] = 8'h55;
        wr_seq(8'h08, 5);
        rd_seq(8'h08, 4);
        check("R4 burst byte0", rbuf[0], 8'h11);
        check("R4 burst byte1", rbuf[1], 8'h22);
        check("R4 burst byte2", rbuf[2], 8'h33);
        check("R4 burst byte3", rbuf[3], 8'h44);
        rd_cur(1);
        check("R7 pointer kept across stop", rbuf[0], 8'h55);

        // R8: wrap from 0x3F to 0x00
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        wr_seq(8'h3F, 2);
        rd_seq(8'h3F, 2);
        check("R8 reg 0x3F", rbuf[0], 8'hC3);
        check("R8 wrapped reg 0x00", rbuf[1], 8'h3C);

        // R9: repeated START mid data byte
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        write_byte(8'h01, ack);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        bus_rstart();
        write_byte({DEV, 1'b1}, ack);
        read_byte(rbuf[0], 1'b0);
        bus_stop();
        check("R9 start abort keeps reg 0x01", rbuf[0], 8'h5A);

        // R9: STOP mid data byte
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        write_byte(8'h02, ack);
        for (int i = 0; i < 3; i++) clock_bit(1'b0, s);
        bus_stop();
        rd_seq(8'h02, 1);
        check("R9 stop abort keeps reg 0x02", rbuf[0], 8'hA5);

        // R10: timeout during address acknowledge
        bus_start();
        for (int i = 7; i >= 1; i--) clock_bit(DEV[i-1], s);
        clock_bit(1'b0, s);
        check("R10 ack driven before hold", sda_oe, 1);
        tick(TMO + 50);
        check("R10 released after timeout", sda_oe, 0);
        bus_stop();

        // R10: timeout mid data byte leaves registers intact
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        write_byte(8'h10, ack);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        tick(TMO + 50);
        bus_stop();
        rd_seq(8'h10, 1);
        check("R10 reg 0x10 unchanged", rbuf[0], 8'h3C);
        rd_seq(8'h08, 1);
        check("R10 reg 0x08 unchanged", rbuf[0], 8'h11);

        // R11: set bit 7 of register 0x27, timeout no longer acts
        wbuf[0] = 8'h80;
        wr_seq(8'h27, 1);
        bus_start();
        for (int i = 7; i >= 1; i--) clock_bit(DEV[i-1], s);
        clock_bit(1'b0, s);
        tick(TMO + 50);
        check("R11 ack still driven", sda_oe, 1);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        bus_stop();
        rd_seq(8'h27, 1);
        check("R11 config readback", rbuf[0], 8'h80);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule